// File: doc/BRIEF.md
# Windowed Address Translation Table

This block translates addresses for a bridge between an on-chip bus and a serial interconnect. It holds a small set of translation windows. Each window has a source base, a size given as a power of two, a translated base and an opaque parameter word. Software sets up the windows through a 32-bit register write and read port.

A lookup port accepts a 64-bit address. One clock later it returns three things: a hit flag, the translated address and the parameter word of the window that matched. On a hit, the address bits inside the window are kept from the input. The bits above the window come from the translated base. When several windows overlap, the entry with the lowest number wins. When no window matches, the response reports a miss and every data field is zero.

Top module: `win_xlate_table`

## Requirements
- R1: After reset every register reads zero, every entry is disabled, `rsp_valid` is low and any lookup misses.
- R2: Entry i occupies byte addresses i*0x20 to i*0x20+0x1F. The offsets within an entry are: 0x00 source-low, 0x04 source-high (address bits 63:32), 0x08 translated-low, 0x0C translated-high (bits 63:32) and 0x10 parameter. A read issued with `reg_rd` shows its data on `reg_rdata` in the following cycle, and `reg_rdata` holds that value until the next read.
- R3: In source-low, bit 0 is the entry enable, bits 6:1 are the size field F and bits 31:12 are base address bits 31:12. Bits 11:7 read back as zero.
- R4: Bits 11:0 of translated-low read back as zero. The parameter register keeps only its low PARAM_W bits, and the rest read zero. Offsets 0x14 to 0x1F read zero. Addresses of entries at or above NUM_WIN are ignored on write and read zero.
- R5: A window spans 2^(F+1) bytes. A lookup address hits an enabled entry when all of its bits above bit F equal the same bits of the source base.
- R6: On a hit, `rsp_addr` takes address bits F:0 from the lookup address and bits 63:F+1 from the translated base. `rsp_param` is the entry's parameter word.
- R7: When several enabled entries match, the lowest-numbered entry supplies the response.
- R8: On a miss, `rsp_hit` is 0 and `rsp_addr` and `rsp_param` are zero.
- R9: `rsp_valid` is high in exactly the cycle after a cycle with `lk_valid` high. When `rsp_valid` is low, the hit, address and parameter outputs are zero.
- R10: An entry whose enable bit is 0 never hits, even if its window covers the address.
- R11: Windows of 4 KB (F=11) and 8 GB (F=32) work, and so does a translated base of zero.
- R12: A lookup in the cycle after a register write uses the written value. A lookup in the same cycle as the write uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register byte address (entry index and offset) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 64 | Lookup address |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | A window matched |
| rsp_addr | output | 64 | Translated address |
| rsp_param | output | PARAM_W | Parameter word of the matching entry |

## Verification
The bench builds the block with NUM_WIN=3 and PARAM_W=24. With three entries, the index field has a code, 3, that names no entry, so the test that writes and reads a nonexistent entry is possible. The 24-bit parameter makes the top byte of the parameter register read back as zero. Three entries are also enough for a small window nested in a larger one and a disjoint 8 GB window, all enabled at once. That lets the bench test priority, the disable bit and the write/lookup ordering against known addresses.

// File: rtl/xlt_pkg.sv
// Package: shared constants, entry record and window mask helper for the
// windowed address translation table. Assumes 64-bit addresses and a
// 32-bit register port with 4 KB minimum base alignment.
package xlt_pkg;

    localparam int ADDR_W  = 64;
    localparam int REG_W   = 32;
    localparam int PAGE_LO = 12;
    localparam int PAGE_W  = ADDR_W - PAGE_LO;
    localparam int SIZE_W  = 6;
    localparam int STRIDE_BITS = 5;

    // Register offsets inside one entry group
    localparam logic [STRIDE_BITS-1:0] OFS_SRC_LO = 5'h00;
    localparam logic [STRIDE_BITS-1:0] OFS_SRC_HI = 5'h04;
    localparam logic [STRIDE_BITS-1:0] OFS_DST_LO = 5'h08;
    localparam logic [STRIDE_BITS-1:0] OFS_DST_HI = 5'h0C;
    localparam logic [STRIDE_BITS-1:0] OFS_PARAM  = 5'h10;

    typedef struct packed {
        logic              en;
        logic [SIZE_W-1:0] sz;
        logic [PAGE_W-1:0] src_pg;
        logic [PAGE_W-1:0] dst_pg;
    } xlt_win_t;

    // Mask of the bits that pass through for a size field f (2^(f+1) bytes)
    function automatic logic [ADDR_W-1:0] win_mask(input logic [SIZE_W-1:0] f);
        logic [SIZE_W:0] n;
        n = {1'b0, f} + 1'b1;
        if (n >= (SIZE_W+1)'(ADDR_W))
            win_mask = '1;
        else
            win_mask = (ADDR_W'(1) << n) - ADDR_W'(1);
    endfunction

endpackage

// File: rtl/xlt_regfile.sv
// Register file: holds the entries and serves the 32-bit register port.
// Assumes PARAM_W <= 32. Writes to absent entries and to unmapped offsets
// are dropped; reads of them return zero. Read data is registered.
module xlt_regfile
    import xlt_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int PARAM_W = 24,
    parameter int IDX_W   = 2,
    parameter int AW      = IDX_W + STRIDE_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic               rd,
    input  logic [AW-1:0]      addr,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata,
    output xlt_win_t           win_o [NUM_WIN],
    output logic [PARAM_W-1:0] prm_o [NUM_WIN]
);

    logic [IDX_W-1:0]       idx;
    logic [STRIDE_BITS-1:0] ofs;
    logic [REG_W-1:0]       rd_next;

    assign idx = addr[AW-1:STRIDE_BITS];
    assign ofs = addr[STRIDE_BITS-1:0];

    xlt_win_t           win_q [NUM_WIN];
    logic [PARAM_W-1:0] prm_q [NUM_WIN];

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_ent
        // Storage of one entry: reset clears, a write updates one register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_q[i] <= '0;
                prm_q[i] <= '0;
            end else if (wr && (idx == IDX_W'(i))) begin
                case (ofs)
                    OFS_SRC_LO: begin
                        win_q[i].en                 <= wdata[0];
                        win_q[i].sz                 <= wdata[SIZE_W:1];
                        win_q[i].src_pg[19:0]       <= wdata[31:12];
                    end
                    OFS_SRC_HI: win_q[i].src_pg[PAGE_W-1:20] <= wdata;
                    OFS_DST_LO: win_q[i].dst_pg[19:0]        <= wdata[31:12];
                    OFS_DST_HI: win_q[i].dst_pg[PAGE_W-1:20] <= wdata;
                    OFS_PARAM:  prm_q[i] <= wdata[PARAM_W-1:0];
                    default: ;
                endcase
            end
        end
        assign win_o[i] = win_q[i];
        assign prm_o[i] = prm_q[i];
    end

    // Read mux: pick the addressed register of the addressed entry
    always_comb begin
        rd_next = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (idx == IDX_W'(i)) begin
                case (ofs)
                    OFS_SRC_LO: rd_next = {win_q[i].src_pg[19:0], 5'b0,
                                           win_q[i].sz, win_q[i].en};
                    OFS_SRC_HI: rd_next = win_q[i].src_pg[PAGE_W-1:20];
                    OFS_DST_LO: rd_next = {win_q[i].dst_pg[19:0], 12'b0};
                    OFS_DST_HI: rd_next = win_q[i].dst_pg[PAGE_W-1:20];
                    OFS_PARAM:  rd_next = REG_W'(prm_q[i]);
                    default:    rd_next = '0;
                endcase
            end
        end
    end

    // Read data register: loads on a read strobe, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd)
            rdata <= rd_next;
    end

endmodule

// File: rtl/xlt_match.sv
// Window matcher for one entry: compares the lookup address with the
// source base above the window size and builds the substituted address.
// Purely combinational; assumes bases are 4 KB aligned.
module xlt_match
    import xlt_pkg::*;
(
    input  xlt_win_t           win,
    input  logic [ADDR_W-1:0]  lk_addr,
    output logic               hit,
    output logic [ADDR_W-1:0]  xaddr
);

    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] src_base;
    logic [ADDR_W-1:0] dst_base;

    // Compare and substitute under the window mask
    always_comb begin
        mask     = win_mask(win.sz);
        src_base = {win.src_pg, {PAGE_LO{1'b0}}};
        dst_base = {win.dst_pg, {PAGE_LO{1'b0}}};
        hit      = win.en && ((lk_addr & ~mask) == (src_base & ~mask));
        xaddr    = (dst_base & ~mask) | (lk_addr & mask);
    end

endmodule

// File: rtl/xlt_pick.sv
// Priority selector: returns the result of the lowest-numbered matching
// entry, or all zeros when nothing matches.
module xlt_pick
    import xlt_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int PARAM_W = 24
) (
    input  logic [NUM_WIN-1:0] hit_v,
    input  logic [ADDR_W-1:0]  xaddr [NUM_WIN],
    input  logic [PARAM_W-1:0] prm   [NUM_WIN],
    output logic               any_hit,
    output logic [ADDR_W-1:0]  sel_addr,
    output logic [PARAM_W-1:0] sel_prm
);

    // Scan from the highest entry down so the lowest match is kept last
    always_comb begin
        any_hit  = 1'b0;
        sel_addr = '0;
        sel_prm  = '0;
        for (int i = NUM_WIN-1; i >= 0; i--) begin
            if (hit_v[i]) begin
                any_hit  = 1'b1;
                sel_addr = xaddr[i];
                sel_prm  = prm[i];
            end
        end
    end

endmodule

// File: rtl/win_xlate_table.sv
// Top: windowed address translation table. Register port programs the
// entries; a lookup is answered one cycle later through registered
// outputs. Synchronous active-low reset; PARAM_W must not exceed 32.
module win_xlate_table
    import xlt_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int PARAM_W = 24,
    localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    localparam int AW     = IDX_W + STRIDE_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [AW-1:0]      reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               lk_valid,
    input  logic [ADDR_W-1:0]  lk_addr,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [ADDR_W-1:0]  rsp_addr,
    output logic [PARAM_W-1:0] rsp_param
);

    xlt_win_t           win   [NUM_WIN];
    logic [PARAM_W-1:0] prm   [NUM_WIN];
    logic [ADDR_W-1:0]  xaddr [NUM_WIN];
    logic [NUM_WIN-1:0] hit_v;
    logic               any_hit;
    logic [ADDR_W-1:0]  sel_addr;
    logic [PARAM_W-1:0] sel_prm;

    xlt_regfile #(
        .NUM_WIN (NUM_WIN),
        .PARAM_W (PARAM_W),
        .IDX_W   (IDX_W),
        .AW      (AW)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .rd    (reg_rd),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .win_o (win),
        .prm_o (prm)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
        xlt_match u_match (
            .win     (win[i]),
            .lk_addr (lk_addr),
            .hit     (hit_v[i]),
            .xaddr   (xaddr[i])
        );
    end

    xlt_pick #(
        .NUM_WIN (NUM_WIN),
        .PARAM_W (PARAM_W)
    ) u_pick (
        .hit_v    (hit_v),
        .xaddr    (xaddr),
        .prm      (prm),
        .any_hit  (any_hit),
        .sel_addr (sel_addr),
        .sel_prm  (sel_prm)
    );

    // Response register: captures the selected result for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_addr  <= '0;
            rsp_param <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && any_hit;
            rsp_addr  <= (lk_valid && any_hit) ? sel_addr : '0;
            rsp_param <= (lk_valid && any_hit) ? sel_prm  : '0;
        end
    end

endmodule

// File: rtl/xlt_checker.sv
// Checker: temporal properties of the translation table ports, bound to
// the top module. Observes only; drives nothing.
module xlt_checker
    import xlt_pkg::*;
#(
    parameter int AW      = 7,
    parameter int PARAM_W = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_rd,
    input logic [AW-1:0]      reg_addr,
    input logic [REG_W-1:0]   reg_rdata,
    input logic               lk_valid,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [ADDR_W-1:0]  rsp_addr,
    input logic [PARAM_W-1:0] rsp_param
);

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid); // R9

    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit && rsp_addr == '0)); // R9

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_addr == '0 && rsp_param == '0)); // R8

    AST_SRCLO_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr[4:0] == 5'h00) |=> (reg_rdata[11:7] == 5'b0)); // R3

    AST_DSTLO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr[4:0] == 5'h08) |=> (reg_rdata[11:0] == 12'b0)); // R4

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr[4:0] > 5'h10) |=> (reg_rdata == '0)); // R4

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata)); // R2

endmodule

bind win_xlate_table xlt_checker #(
    .AW      (AW),
    .PARAM_W (PARAM_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .lk_valid  (lk_valid),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_addr  (rsp_addr),
    .rsp_param (rsp_param)
);

// File: tb/test_win_xlate_table.sv
// Directed bench for the windowed address translation table.
module test_win_xlate_table;

    localparam int NW = 3;
    localparam int PW = 24;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          lk_valid = 1'b0;
    logic [63:0]   lk_addr = '0;
    logic          rsp_valid;
    logic          rsp_hit;
    logic [63:0]   rsp_addr;
    logic [PW-1:0] rsp_param;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    win_xlate_table #(.NUM_WIN(NW), .PARAM_W(PW)) i_win_xlate_table (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_addr(rsp_addr), .rsp_param(rsp_param)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        chk(req, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic look_chk(input string req, input logic [63:0] a, input logic eh,
                            input logic [63:0] ea, input logic [PW-1:0] ep);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        chk({req, " valid"}, 64'(rsp_valid), 64'd1);
        chk({req, " hit"},   64'(rsp_hit),   64'(eh));
        chk({req, " addr"},  rsp_addr,       ea);
        chk({req, " param"}, 64'(rsp_param), 64'(ep));
    endtask

    task automatic t_reset();
        chk("R1 idle valid", 64'(rsp_valid), 64'd0);
        rd_chk("R1 src-low e0", 7'h00, 32'h0);
        rd_chk("R1 param e2", 7'h50, 32'h0);
        look_chk("R1 lookup after reset", 64'h0, 1'b0, 64'h0, '0);
    endtask

    task automatic t_regmap();
        for (int k = 0; k < 5; k++) wr(7'(8'h20 + 8'(4*k)), 32'hFFFF_FFFF);
        rd_chk("R3 src-low fields", 7'h20, 32'hFFFF_F07F);
        rd_chk("R2 src-high",       7'h24, 32'hFFFF_FFFF);
        rd_chk("R4 dst-low low bits", 7'h28, 32'hFFFF_F000);
        rd_chk("R2 dst-high",       7'h2C, 32'hFFFF_FFFF);
        rd_chk("R4 param width",    7'h30, 32'h00FF_FFFF);
        rd_chk("R4 unmapped offset", 7'h34, 32'h0);
        wr(7'h60, 32'hFFFF_FFFF);
        rd_chk("R4 absent entry", 7'h60, 32'h0);
        rd_chk("R2 other entry untouched", 7'h00, 32'h0);
        for (int k = 0; k < 5; k++) wr(7'(8'h20 + 8'(4*k)), 32'h0);
    endtask

    task automatic t_basic();
        wr(7'h00, 32'h2C1C_0017);
        wr(7'h04, 32'h0);
        wr(7'h08, 32'h2345_6000);
        wr(7'h0C, 32'h1);
        wr(7'h10, 32'h42_0004);
        look_chk("R6 R11 4KB hit", 64'h2C1C_0ABC, 1'b1, 64'h1_2345_6ABC, 24'h42_0004);
        look_chk("R8 outside 4KB", 64'h2C1C_1ABC, 1'b0, 64'h0, '0);
        look_chk("R5 upper bits differ", 64'hFFFF_FFFF_2C1C_0ABC, 1'b0, 64'h0, '0);
    endtask

    task automatic t_large();
        wr(7'h20, 32'h0000_0041);
        wr(7'h24, 32'h0000_0040);
        wr(7'h28, 32'h0);
        wr(7'h2C, 32'h0);
        wr(7'h30, 32'h4E_0004);
        rd_chk("R3 size field 32", 7'h20, 32'h0000_0041);
        look_chk("R11 8GB zero base", 64'h41_2345_6789, 1'b1, 64'h1_2345_6789, 24'h4E_0004);
        look_chk("R5 below 8GB window", 64'h3F_FFFF_FFFF, 1'b0, 64'h0, '0);
    endtask

    task automatic t_priority();
        wr(7'h40, 32'h5000_0035);
        wr(7'h44, 32'h0);
        wr(7'h48, 32'h0);
        wr(7'h4C, 32'h9);
        wr(7'h50, 32'h02_0000);
        wr(7'h00, 32'h5000_1017);
        wr(7'h08, 32'h7000_0000);
        wr(7'h0C, 32'h0);
        wr(7'h10, 32'h1);
        look_chk("R7 lowest wins", 64'h5000_1234, 1'b1, 64'h7000_0234, 24'h1);
        look_chk("R5 large window", 64'h5000_2234, 1'b1, 64'h9_0000_2234, 24'h02_0000);
        wr(7'h00, 32'h5000_1016);
        look_chk("R10 disabled entry", 64'h5000_1234, 1'b1, 64'h9_0000_1234, 24'h02_0000);
    endtask

    task automatic t_order();
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 7'h00; reg_wdata = 32'h5000_1017;
        lk_valid = 1'b1; lk_addr = 64'h5000_1234;
        @(negedge clk);
        reg_wr = 1'b0; lk_valid = 1'b0;
        chk("R12 same-cycle uses old", rsp_addr, 64'h9_0000_1234);
        look_chk("R12 next lookup uses new", 64'h5000_1234, 1'b1, 64'h7000_0234, 24'h1);
        @(negedge clk);
        chk("R9 valid drops", 64'(rsp_valid), 64'd0);
        chk("R9 idle hit zero", 64'(rsp_hit), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_basic();
        t_large();
        t_priority();
        t_order();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule